// File: doc/BRIEF.md
# Bytecode Branch and Next-PC Unit

This block resolves the control-flow instructions of a 64-bit bytecode machine and produces the program counter of the next instruction. Each issued instruction presents its byte-address PC, a 4-bit jump operation code, a class bit that selects a 64-bit or a 32-bit compare, the destination operand, the second operand (already chosen by the decoder between register and immediate), a signed 16-bit slot offset and a flag that marks a 16-byte instruction.

One clock after issue, the unit reports the next PC and whether the branch was taken. It also raises single-cycle strobes for calls, program exit and illegal jump encodings. The call strobe carries the 32-bit call identifier taken from the immediate. A handler outside the block acts on these strobes. Branch offsets count 8-byte slots and are measured from the slot that follows the branch. The compare set covers equality, unsigned and signed ordering, and a bit-test.

Top module: `bpu_branch_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is cleared to zero after that edge.
- R2: Code 1 (equal) is taken when the operands are equal. Code 5 (not equal) is taken when they differ.
- R3: Codes 2 (greater), 3 (greater or equal), 10 (less) and 11 (less or equal) compare the operands as unsigned numbers.
- R4: Codes 6, 7, 12 and 13 are the same four orderings as in R3, but compare the operands as two's-complement signed numbers.
- R5: Code 4 (bit test) is taken when the bitwise AND of the two operands is nonzero.
- R6: With `is_jmp32` = 1, every compare uses only operand bits 31:0, and bit 31 is the sign for signed compares. With `is_jmp32` = 0, all 64 bits are compared.
- R7: A taken branch sets `pc_next` = `pc_cur` + (sign-extended `br_off` + 1) × 8, computed modulo 2^64.
- R8: When the branch is not taken, `pc_next` = `pc_cur` + 8, or `pc_cur` + 16 when `insn_long` = 1.
- R9: Code 0 with `is_jmp32` = 0 is an unconditional jump. It is always taken and ignores both operands.
- R10: Code 8 raises `call_stb` for one cycle and loads `call_id` with `opnd_src[31:0]`. Code 9 raises `exit_stb` for one cycle. Neither code counts as taken, and both give the fall-through PC.
- R11: Codes 14 and 15 in either class, and code 0 with `is_jmp32` = 1, raise `illegal_stb` for one cycle. They are not taken and give the fall-through PC.
- R12: All results appear one cycle after an `issue_vld` edge, and `pc_vld` marks them. After a cycle with no issue, `pc_vld`, `br_taken` and all strobes are 0, while `pc_next` and `call_id` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_vld | input | 1 | A jump-class instruction is presented this cycle |
| pc_cur | input | 64 | Byte address of the presented instruction |
| op_code | input | 4 | Jump operation code |
| is_jmp32 | input | 1 | 1 selects the 32-bit compare class |
| opnd_dst | input | 64 | Destination register operand |
| opnd_src | input | 64 | Second operand, either a register or the immediate |
| br_off | input | 16 | Signed branch offset in 8-byte slots |
| insn_long | input | 1 | 1 marks a 16-byte instruction |
| pc_vld | output | 1 | The result outputs hold a new result |
| pc_next | output | 64 | Next program counter |
| br_taken | output | 1 | The branch was taken |
| call_stb | output | 1 | One-cycle call request |
| exit_stb | output | 1 | One-cycle program exit |
| illegal_stb | output | 1 | One-cycle illegal jump encoding |
| call_id | output | 32 | Call target or helper identifier |

## Verification
Within a single result cycle, the compare outcome and the target arithmetic meet: a taken branch must select the offset-derived target in the same cycle that the condition resolves. The fall-through step must win whenever a call, exit or illegal strobe fires. The bench drives a call or an exit with an offset that would produce a distant target and expects the fall-through PC beside the strobe. It also drives an offset of all ones, where a taken branch must land on its own PC. A behavioural model recomputes every output on every clock, including back-to-back calls and an idle cycle after a strobe.

// File: rtl/bpu_pkg.sv
// Package: shared types for the branch and next-PC unit.
// Assumes jump operation codes are 4 bits wide; the code values are fixed
// because an upstream decoder produces them.
package bpu_pkg;

    typedef enum logic [3:0] {
        JC_ALWAYS = 4'h0,
        JC_EQ     = 4'h1,
        JC_UGT    = 4'h2,
        JC_UGE    = 4'h3,
        JC_BITS   = 4'h4,
        JC_NE     = 4'h5,
        JC_SGT    = 4'h6,
        JC_SGE    = 4'h7,
        JC_CALL   = 4'h8,
        JC_EXIT   = 4'h9,
        JC_ULT    = 4'hA,
        JC_ULE    = 4'hB,
        JC_SLT    = 4'hC,
        JC_SLE    = 4'hD
    } jcode_e;

    // Raw relations between the two operands of one compare lane.
    typedef struct packed {
        logic eq;
        logic ult;
        logic slt;
        logic anyset;
    } cmp_flags_t;

    // Instruction category derived from the code and the class.
    typedef struct packed {
        logic is_cond;
        logic is_uncond;
        logic is_call;
        logic is_exit;
        logic is_illegal;
    } jdec_t;

endpackage

// File: rtl/bpu_decode.sv
// Module: bpu_decode
// Sorts a jump operation code into conditional, unconditional, call, exit
// or illegal. Purely combinational. Assumes exactly one category is set
// for each code/class pair.
module bpu_decode
    import bpu_pkg::*;
(
    input  logic [3:0] op_code,
    input  logic       narrow,
    output jdec_t      dec
);

    logic code_hi_free;

    // Codes 14 and 15 have no meaning in either class.
    assign code_hi_free = (op_code == 4'hE) || (op_code == 4'hF);

    // Purpose: classify the instruction.
    always_comb begin
        dec            = '0;
        dec.is_illegal = code_hi_free || (narrow && op_code == JC_ALWAYS);
        if (!dec.is_illegal) begin
            dec.is_uncond = (op_code == JC_ALWAYS);
            dec.is_call   = (op_code == JC_CALL);
            dec.is_exit   = (op_code == JC_EXIT);
            dec.is_cond   = !dec.is_uncond && !dec.is_call && !dec.is_exit;
        end
    end

endmodule

// File: rtl/bpu_compare.sv
// Module: bpu_compare
// Evaluates the branch condition. One compare lane covers the full width
// and one covers the low NARROW bits; the class bit picks a lane. Assumes
// NARROW <= XLEN. Combinational.
module bpu_compare
    import bpu_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int NARROW = 32
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            narrow,
    input  logic [3:0]      op_code,
    output logic            cond_true
);

    localparam int NLANES = 2;

    cmp_flags_t lane_flags [NLANES];
    cmp_flags_t sel;

    // Each lane computes its relations over its own width.
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        localparam int W = (g == 0) ? XLEN : NARROW;
        logic [W-1:0] a;
        logic [W-1:0] b;
        assign a = opa[W-1:0];
        assign b = opb[W-1:0];
        assign lane_flags[g] = '{eq:     (a == b),
                                 ult:    (a < b),
                                 slt:    ($signed(a) < $signed(b)),
                                 anyset: (|(a & b))};
    end

    assign sel = narrow ? lane_flags[1] : lane_flags[0];

    // Purpose: map the code onto the selected lane's relations.
    always_comb begin
        case (jcode_e'(op_code))
            JC_EQ:   cond_true = sel.eq;
            JC_NE:   cond_true = !sel.eq;
            JC_UGT:  cond_true = !sel.ult && !sel.eq;
            JC_UGE:  cond_true = !sel.ult;
            JC_ULT:  cond_true = sel.ult;
            JC_ULE:  cond_true = sel.ult || sel.eq;
            JC_SGT:  cond_true = !sel.slt && !sel.eq;
            JC_SGE:  cond_true = !sel.slt;
            JC_SLT:  cond_true = sel.slt;
            JC_SLE:  cond_true = sel.slt || sel.eq;
            JC_BITS: cond_true = sel.anyset;
            default: cond_true = 1'b0;
        endcase
    end

endmodule

// File: rtl/bpu_target.sv
// Module: bpu_target
// Computes both next-PC candidates: the branch target, counted in slots from
// the following slot, and the fall-through address. Assumes SLOT_BYTES is a
// power of two. Combinational, wraps modulo 2^PCW.
module bpu_target #(
    parameter int PCW        = 64,
    parameter int OFFW       = 16,
    parameter int SLOT_BYTES = 8,
    parameter int LONG_BYTES = 16
) (
    input  logic [PCW-1:0]  pc,
    input  logic [OFFW-1:0] off,
    input  logic            long_insn,
    output logic [PCW-1:0]  pc_target,
    output logic [PCW-1:0]  pc_fall
);

    localparam int           SLOT_SH   = $clog2(SLOT_BYTES);
    localparam logic [PCW-1:0] SLOT_STEP = PCW'(SLOT_BYTES);
    localparam logic [PCW-1:0] LONG_STEP = PCW'(LONG_BYTES);

    logic [PCW-1:0] off_ext;
    logic [PCW-1:0] off_slots;

    assign off_ext   = {{(PCW-OFFW){off[OFFW-1]}}, off};
    assign off_slots = off_ext + PCW'(1);
    assign pc_target = pc + (off_slots << SLOT_SH);
    assign pc_fall   = pc + (long_insn ? LONG_STEP : SLOT_STEP);

endmodule

// File: rtl/bpu_branch_unit.sv
// Module: bpu_branch_unit (top)
// Resolves one jump-class instruction per issue and registers the next PC,
// the taken flag and the call/exit/illegal strobes. Assumes the second
// operand is already selected between register and immediate.
// Synchronous active-low reset.
module bpu_branch_unit
    import bpu_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int NARROW     = 32,
    parameter int OFFW       = 16,
    parameter int IDW        = 32,
    parameter int SLOT_BYTES = 8,
    parameter int LONG_BYTES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_vld,
    input  logic [XLEN-1:0] pc_cur,
    input  logic [3:0]      op_code,
    input  logic            is_jmp32,
    input  logic [XLEN-1:0] opnd_dst,
    input  logic [XLEN-1:0] opnd_src,
    input  logic [OFFW-1:0] br_off,
    input  logic            insn_long,
    output logic            pc_vld,
    output logic [XLEN-1:0] pc_next,
    output logic            br_taken,
    output logic            call_stb,
    output logic            exit_stb,
    output logic            illegal_stb,
    output logic [IDW-1:0]  call_id
);

    localparam logic [XLEN-1:0] SLOT_STEP = XLEN'(SLOT_BYTES);
    localparam logic [XLEN-1:0] LONG_STEP = XLEN'(LONG_BYTES);

    jdec_t           dec;
    logic            cond_true;
    logic            take;
    logic [XLEN-1:0] pc_target;
    logic [XLEN-1:0] pc_fall;

    bpu_decode u_decode (
        .op_code (op_code),
        .narrow  (is_jmp32),
        .dec     (dec)
    );

    bpu_compare #(.XLEN(XLEN), .NARROW(NARROW)) u_compare (
        .opa       (opnd_dst),
        .opb       (opnd_src),
        .narrow    (is_jmp32),
        .op_code   (op_code),
        .cond_true (cond_true)
    );

    bpu_target #(
        .PCW(XLEN), .OFFW(OFFW), .SLOT_BYTES(SLOT_BYTES), .LONG_BYTES(LONG_BYTES)
    ) u_target (
        .pc        (pc_cur),
        .off       (br_off),
        .long_insn (insn_long),
        .pc_target (pc_target),
        .pc_fall   (pc_fall)
    );

    assign take = dec.is_uncond || (dec.is_cond && cond_true);

    // Purpose: register the result; strobes last one cycle per issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_vld      <= 1'b0;
            pc_next     <= '0;
            br_taken    <= 1'b0;
            call_stb    <= 1'b0;
            exit_stb    <= 1'b0;
            illegal_stb <= 1'b0;
            call_id     <= '0;
        end else begin
            pc_vld      <= issue_vld;
            br_taken    <= issue_vld && take;
            call_stb    <= issue_vld && dec.is_call;
            exit_stb    <= issue_vld && dec.is_exit;
            illegal_stb <= issue_vld && dec.is_illegal;
            if (issue_vld) begin
                pc_next <= take ? pc_target : pc_fall;
            end
            if (issue_vld && dec.is_call) begin
                call_id <= opnd_src[IDW-1:0];
            end
        end
    end

    // R12
    issue_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld |=> pc_vld);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_vld |=> ($stable(pc_next) && !br_taken && !call_stb && !exit_stb));

    // R8
    fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_vld && !br_taken) |->
        (pc_next == $past(pc_cur) + ($past(insn_long) ? LONG_STEP : SLOT_STEP)));

    // R7
    self_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_vld && br_taken && ($past(br_off) == '1)) |-> (pc_next == $past(pc_cur)));

    // R11
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_stb |-> (!br_taken && !call_stb && !exit_stb));

    // R10
    call_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_stb || exit_stb) |-> (pc_vld && !br_taken && $onehot0({call_stb, exit_stb})));

endmodule

// File: tb/bpu_branch_unit_tb.sv
// Bench: drives one instruction (or an idle slot) per clock and compares
// every output each clock against a behavioural model.
module bpu_branch_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_vld;
    logic [63:0] pc_cur;
    logic [3:0]  op_code;
    logic        is_jmp32;
    logic [63:0] opnd_dst;
    logic [63:0] opnd_src;
    logic [15:0] br_off;
    logic        insn_long;
    logic        pc_vld;
    logic [63:0] pc_next;
    logic        br_taken;
    logic        call_stb;
    logic        exit_stb;
    logic        illegal_stb;
    logic [31:0] call_id;

    int checks = 0;
    int fails  = 0;

    logic        e_vld, e_taken, e_call, e_exit, e_ill;
    logic [63:0] e_pc;
    logic [31:0] e_id;

    always #(CLK_PERIOD/2) clk = ~clk;

    bpu_branch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .pc_cur(pc_cur),
        .op_code(op_code), .is_jmp32(is_jmp32), .opnd_dst(opnd_dst),
        .opnd_src(opnd_src), .br_off(br_off), .insn_long(insn_long),
        .pc_vld(pc_vld), .pc_next(pc_next), .br_taken(br_taken),
        .call_stb(call_stb), .exit_stb(exit_stb), .illegal_stb(illegal_stb),
        .call_id(call_id)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "pc_vld",      64'(pc_vld),      64'(e_vld));
        check(tag, "pc_next",     pc_next,          e_pc);
        check(tag, "br_taken",    64'(br_taken),    64'(e_taken));
        check(tag, "call_stb",    64'(call_stb),    64'(e_call));
        check(tag, "exit_stb",    64'(exit_stb),    64'(e_exit));
        check(tag, "illegal_stb", 64'(illegal_stb), 64'(e_ill));
        check(tag, "call_id",     64'(call_id),     64'(e_id));
    endtask

    // Behavioural reference: updates expected outputs for one clock.
    function automatic void model(input logic v, input logic [63:0] pc, input int code,
                                  input logic nar, input logic [63:0] d, input logic [63:0] s,
                                  input logic [15:0] off, input logic lng);
        logic [63:0] ua, ub;
        longint      sa, sb;
        logic        ill, cond, tk;
        e_vld = v; e_taken = 0; e_call = 0; e_exit = 0; e_ill = 0;
        if (!v) return;
        ua = nar ? {32'h0, d[31:0]} : d;
        ub = nar ? {32'h0, s[31:0]} : s;
        sa = nar ? longint'($signed(d[31:0])) : $signed(d);
        sb = nar ? longint'($signed(s[31:0])) : $signed(s);
        ill  = (code >= 14) || (nar && code == 0);
        cond = 0;
        if (code == 1)  cond = (ua == ub);
        if (code == 5)  cond = (ua != ub);
        if (code == 2)  cond = (ua > ub);
        if (code == 3)  cond = (ua >= ub);
        if (code == 10) cond = (ua < ub);
        if (code == 11) cond = (ua <= ub);
        if (code == 6)  cond = (sa > sb);
        if (code == 7)  cond = (sa >= sb);
        if (code == 12) cond = (sa < sb);
        if (code == 13) cond = (sa <= sb);
        if (code == 4)  cond = ((ua & ub) != 0);
        if (code == 0 && !nar) cond = 1;
        tk = cond && !ill;
        e_taken = tk;
        e_call  = (code == 8);
        e_exit  = (code == 9);
        e_ill   = ill;
        if (tk) e_pc = pc + 64'((longint'($signed(off)) + 1) * 8);
        else    e_pc = pc + (lng ? 64'd16 : 64'd8);
        if (code == 8) e_id = s[31:0];
    endfunction

    task automatic step(input string tag, input logic v, input logic [63:0] pc,
                        input int code, input logic nar, input logic [63:0] d,
                        input logic [63:0] s, input logic [15:0] off, input logic lng);
        @(negedge clk);
        issue_vld = v; pc_cur = pc; op_code = 4'(code); is_jmp32 = nar;
        opnd_dst = d; opnd_src = s; br_off = off; insn_long = lng;
        model(v, pc, code, nar, d, s, off, lng);
        @(posedge clk);
        #2;
        compare_all(tag);
    endtask

    function automatic logic [63:0] pick();
        int k = $urandom_range(0, 6);
        case (k)
            0: return 64'd0;
            1: return 64'd1;
            2: return '1;
            3: return 64'h0000_0000_8000_0000;
            4: return 64'h0000_0001_0000_0000;
            5: return 64'h8000_0000_0000_0000;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        rst_n = 0; issue_vld = 1; pc_cur = '1; op_code = 4'h8; is_jmp32 = 0;
        opnd_dst = '0; opnd_src = '1; br_off = '0; insn_long = 0;
        e_vld = 0; e_pc = '0; e_taken = 0; e_call = 0; e_exit = 0; e_ill = 0; e_id = '0;
        repeat (3) @(posedge clk);
        #2;
        compare_all("R1 reset");
        @(negedge clk);
        rst_n = 1; issue_vld = 0;

        step("R2 eq taken",    1, 64'h1000, 1, 0, 64'd7, 64'd7, 16'd3, 0);
        step("R2 eq not",      1, 64'h1000, 1, 0, 64'd7, 64'd8, 16'd3, 0);
        step("R2 ne taken",    1, 64'h2000, 5, 0, 64'd7, 64'd8, 16'd2, 0);
        step("R3 ugt big",     1, 64'h3000, 2, 0, '1, 64'd1, 16'd4, 0);
        step("R3 uge eq",      1, 64'h3000, 3, 0, 64'd9, 64'd9, 16'd4, 0);
        step("R3 ult",         1, 64'h3000, 10, 0, 64'd1, '1, 16'd4, 0);
        step("R3 ule not",     1, 64'h3000, 11, 0, 64'd2, 64'd1, 16'd4, 0);
        step("R4 sgt neg",     1, 64'h4000, 6, 0, '1, 64'd1, 16'd5, 0);
        step("R4 slt neg",     1, 64'h4000, 12, 0, '1, 64'd1, 16'd5, 0);
        step("R4 sge eq",      1, 64'h4000, 7, 0, 64'd3, 64'd3, 16'd5, 0);
        step("R4 sle",         1, 64'h4000, 13, 0, 64'h8000_0000_0000_0000, 64'd0, 16'd5, 0);
        step("R5 set none",    1, 64'h5000, 4, 0, 64'hF0, 64'h0F, 16'd6, 0);
        step("R5 set hit",     1, 64'h5000, 4, 0, 64'hF0, 64'h18, 16'd6, 0);
        step("R6 eq low32",    1, 64'h6000, 1, 1, 64'h1_0000_0005, 64'd5, 16'd1, 0);
        step("R6 eq wide",     1, 64'h6000, 1, 0, 64'h1_0000_0005, 64'd5, 16'd1, 0);
        step("R6 slt bit31",   1, 64'h6000, 12, 1, 64'h8000_0000, 64'd0, 16'd1, 0);
        step("R6 slt wide",    1, 64'h6000, 12, 0, 64'h8000_0000, 64'd0, 16'd1, 0);
        step("R6 set high",    1, 64'h6000, 4, 1, 64'hF_0000_0000, '1, 16'd1, 0);
        step("R7 self loop",   1, 64'h7000, 0, 0, 64'd0, 64'd0, 16'hFFFF, 0);
        step("R7 max fwd",     1, 64'h7000, 0, 0, 64'd0, 64'd0, 16'h7FFF, 0);
        step("R7 wrap back",   1, 64'h10, 0, 0, 64'd0, 64'd0, 16'h8000, 1);
        step("R8 long fall",   1, 64'h8000, 1, 0, 64'd1, 64'd2, 16'd9, 1);
        step("R8 top wrap",    1, '1 - 64'd7, 5, 0, 64'd1, 64'd1, 16'd9, 1);
        step("R9 ja ignores",  1, 64'h9000, 0, 0, '1, 64'd5, 16'd12, 1);
        step("R10 call",       1, 64'hA000, 8, 0, 64'd0, 64'hDEAD_BEEF_1234_5678, 16'h0100, 0);
        step("R10 call again", 1, 64'hA008, 8, 1, 64'd0, 64'h0000_0000_0000_0042, 16'h0100, 1);
        step("R10 exit",       1, 64'hA018, 9, 0, 64'd0, 64'd77, 16'h0200, 0);
        step("R12 idle",       0, 64'hBEEF, 1, 0, 64'd0, 64'd0, 16'd0, 0);
        step("R12 idle again", 0, 64'hBEEF, 8, 0, 64'd0, 64'd9, 16'd0, 0);
        step("R11 code E",     1, 64'hB000, 14, 0, 64'd1, 64'd1, 16'd3, 0);
        step("R11 code F",     1, 64'hB000, 15, 1, 64'd1, 64'd1, 16'd3, 1);
        step("R11 ja32",       1, 64'hB000, 0, 1, 64'd1, 64'd1, 16'd3, 0);

        for (int i = 0; i < 500; i++) begin
            step("mix", ($urandom_range(0, 7) != 0), {$urandom, $urandom},
                 $urandom_range(0, 15), 1'($urandom_range(0, 1)), pick(), pick(),
                 16'($urandom), 1'($urandom_range(0, 1)));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule